// File: doc/BRIEF.md
# Instruction Fetch Breakpoint Unit

This unit gives a pipelined CPU with delayed branches a set of hardware breakpoints on instruction fetch. Each channel has a break address, an 8-bit condition word, a before/after selector and a sticky match flag. The unit compares every fetch address against the armed channels and records the result in a small table indexed by the tag that the pipeline gives each fetched instruction. It then acts only when the pipeline says, with the same tag, that the instruction executes or has been discarded.

A break taken before execution is raised at the boundary of the matched instruction. A break taken after execution waits for the next instruction that executes. A taken delayed branch and its delay slot are confirmed together as one pair. A before-execution hit on the slot is therefore raised at the branch, and an after-execution hit on either instruction of the pair waits for the first instruction at the branch target. The request is a single-cycle pulse that carries a cause vector and the tag of the boundary instruction. While the CPU block input is high no request is raised, but matching and flag setting continue.

Top module: `ifbrk_unit`

## Requirements
- R1: After reset, brk_req is 0, brk_cause and brk_tag are 0, and every configuration slot reads back 0.
- R2: A channel is armed only when its condition word reads bus [1:0]=01, kind [3:2]=01, direction [5:4]=01 and size [7:6]=10 or 11. For example, 0x95 (word) and 0xD5 (longword) arm the channel. Any other condition word never matches.
- R3: A channel whose break address has bit 0 set never matches and never raises a break, even when the fetch address is equal to it.
- R4: A channel matches a fetch only when fetch_addr equals its break address on all AW bits. Configuration slots are selected with cfg_sel: 2c is the address of channel c, 2c+1 its condition, 2N the before/after bits (bit c=1 means after execution), and 2N+1 the flags.
- R5: With bit c of the before/after word at 0, an executed instruction that matched channel c produces brk_req for exactly one cycle, one clock after its retire cycle. brk_tag equals its tag and brk_cause bit c is set.
- R6: With bit c of the before/after word at 1, the break comes one clock after the retire cycle of the next executed instruction. brk_tag is that instruction's tag and brk_cause bit N+c is set.
- R7: A retire with ret_cancel=1 never produces a break and never sets a flag. It neither fires nor clears a pending after-execution break.
- R8: In a pair retire (ret_pair=1), a before-execution hit on the delay slot produces the break with the branch's tag.
- R9: An after-execution hit on the branch or its delay slot in a pair produces the break at the next executed instruction after the pair, which is the branch target.
- R10: A conditional delayed branch that is not taken retires alone (ret_pair=0), so the instruction after it is treated as an ordinary instruction.
- R11: While cpu_block is 1 in a retire cycle, no break is raised, and flags are still set. A pending after-execution break that falls due in a blocked cycle is dropped.
- R12: Flags are sticky. Writing the flag slot clears each flag whose write bit is 0 and keeps each flag whose write bit is 1. A new match in the same cycle wins.
- R13: When both channels hit the same executed instruction, exactly one pulse is raised with both cause bits set, and both flags are set.
- R14: Each address, condition and before/after slot reads back the value last written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | SW | Configuration slot select |
| cfg_wdata | input | AW | Configuration write data |
| cfg_rdata | output | AW | Configuration read data for cfg_sel |
| fetch_valid | input | 1 | Instruction fetch presented this cycle |
| fetch_addr | input | AW | Fetch address |
| fetch_tag | input | TW | Tag assigned to the fetched instruction |
| ret_valid | input | 1 | Retire or cancel event this cycle |
| ret_tag | input | TW | Tag of the retiring instruction (the branch in a pair) |
| ret_cancel | input | 1 | 1 = instruction discarded (overrun fetch) |
| ret_pair | input | 1 | 1 = taken delayed branch retiring with its slot |
| ret_slot_tag | input | TW | Tag of the delay slot when ret_pair=1 |
| cpu_block | input | 1 | CPU block bit; suppresses break requests |
| brk_req | output | 1 | Single-cycle break request |
| brk_cause | output | 2N | Bits [N-1:0] before-execution per channel, [2N-1:N] after-execution |
| brk_tag | output | TW | Tag of the instruction before which the break is taken |

## Verification
The bench builds the unit with two channels, a 16-bit address and a 3-bit tag. The short addresses keep the programs readable. The 8-entry tag table wraps many times during straight-line runs, so stale table entries from reused tags are exercised. The two channels allow both a single request carrying two cause bits and the coexistence of a before-execution channel with an after-execution channel.

// File: rtl/ifbrk_pkg.sv
`timescale 1ns/1ps
package ifbrk_pkg;
  localparam int COND_W = 8;

  // condition word: size [7:6], dir [5:4], kind [3:2], bus [1:0]
  typedef struct packed {
    logic [1:0] size;
    logic [1:0] dir;
    logic [1:0] kind;
    logic [1:0] bus;
  } cond_t;

  localparam logic [1:0] BUS_CORE   = 2'b01;
  localparam logic [1:0] KIND_FETCH = 2'b01;
  localparam logic [1:0] DIR_READ   = 2'b01;
  localparam logic [1:0] SIZE_WORD  = 2'b10;
  localparam logic [1:0] SIZE_LONG  = 2'b11;

  function automatic logic fetch_cond_ok(input cond_t c);
    return (c.bus == BUS_CORE) && (c.kind == KIND_FETCH) && (c.dir == DIR_READ) &&
           ((c.size == SIZE_WORD) || (c.size == SIZE_LONG));
  endfunction

  function automatic logic chan_armed(input cond_t c, input logic addr_lsb);
    return fetch_cond_ok(c) && !addr_lsb;
  endfunction
endpackage

// File: rtl/ifbrk_chan.sv
`timescale 1ns/1ps
module ifbrk_chan
  import ifbrk_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_addr,
  input  logic          wr_cond,
  input  logic          wr_post,
  input  logic          post_wval,
  input  logic [AW-1:0] wdata,
  input  logic          flag_we,
  input  logic          flag_wval,
  input  logic          flag_set,
  input  logic [AW-1:0] fetch_addr,
  output logic [AW-1:0] addr_q,
  output cond_t         cond_q,
  output logic          post_q,
  output logic          armed,
  output logic          fetch_hit,
  output logic          flag_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cond_q <= '0;
      post_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (wr_addr) addr_q <= wdata;
      if (wr_cond) cond_q <= cond_t'(wdata[COND_W-1:0]);
      if (wr_post) post_q <= post_wval;
      if (flag_set)                  flag_q <= 1'b1;
      else if (flag_we && !flag_wval) flag_q <= 1'b0;
    end
  end

  assign armed     = chan_armed(cond_q, addr_q[0]);
  assign fetch_hit = armed && (fetch_addr == addr_q);
endmodule

// File: rtl/ifbrk_tagtab.sv
`timescale 1ns/1ps
module ifbrk_tagtab #(
  parameter int NCH = 2,
  parameter int TW  = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [TW-1:0]  wr_tag,
  input  logic [NCH-1:0] wr_hits,
  input  logic [TW-1:0]  rd_tag_a,
  input  logic [TW-1:0]  rd_tag_b,
  output logic [NCH-1:0] rd_hits_a,
  output logic [NCH-1:0] rd_hits_b
);
  localparam int DEPTH = 1 << TW;

  logic [NCH-1:0] tab [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) tab[i] <= '0;
    end else if (wr_en) begin
      tab[wr_tag] <= wr_hits;
    end
  end

  assign rd_hits_a = tab[rd_tag_a];
  assign rd_hits_b = tab[rd_tag_b];
endmodule

// File: rtl/ifbrk_seq.sv
`timescale 1ns/1ps
module ifbrk_seq #(
  parameter int NCH = 2,
  parameter int TW  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ret_valid,
  input  logic             ret_cancel,
  input  logic             ret_pair,
  input  logic [TW-1:0]    ret_tag,
  input  logic [NCH-1:0]   hits_main,
  input  logic [NCH-1:0]   hits_slot,
  input  logic [NCH-1:0]   post_sel,
  input  logic             blk,
  output logic             exec,
  output logic [NCH-1:0]   conf_hits,
  output logic [NCH-1:0]   pend_q,
  output logic             brk_req,
  output logic [2*NCH-1:0] brk_cause,
  output logic [TW-1:0]    brk_tag
);
  logic [NCH-1:0]   pre_now;
  logic [NCH-1:0]   post_now;
  logic [2*NCH-1:0] fire_vec;
  logic             fire;

  assign exec      = ret_valid && !ret_cancel;
  assign conf_hits = exec ? (hits_main | (ret_pair ? hits_slot : '0)) : '0;
  assign pre_now   = conf_hits & ~post_sel;
  assign post_now  = conf_hits & post_sel;
  assign fire_vec  = {(exec ? pend_q : '0), pre_now};
  assign fire      = (|fire_vec) && !blk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= '0;
      brk_req   <= 1'b0;
      brk_cause <= '0;
      brk_tag   <= '0;
    end else begin
      brk_req   <= fire;
      brk_cause <= fire ? fire_vec : '0;
      brk_tag   <= fire ? ret_tag : '0;
      if (exec) pend_q <= post_now;
    end
  end
endmodule

// File: rtl/ifbrk_unit.sv
`timescale 1ns/1ps
module ifbrk_unit
  import ifbrk_pkg::*;
#(
  parameter int NCH = 2,
  parameter int AW  = 32,
  parameter int TW  = 3,
  localparam int SW = $clog2(2*NCH+2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [SW-1:0]    cfg_sel,
  input  logic [AW-1:0]    cfg_wdata,
  output logic [AW-1:0]    cfg_rdata,
  input  logic             fetch_valid,
  input  logic [AW-1:0]    fetch_addr,
  input  logic [TW-1:0]    fetch_tag,
  input  logic             ret_valid,
  input  logic [TW-1:0]    ret_tag,
  input  logic             ret_cancel,
  input  logic             ret_pair,
  input  logic [TW-1:0]    ret_slot_tag,
  input  logic             cpu_block,
  output logic             brk_req,
  output logic [2*NCH-1:0] brk_cause,
  output logic [TW-1:0]    brk_tag
);
  localparam logic [SW-1:0] SEL_CTRL = SW'(2*NCH);
  localparam logic [SW-1:0] SEL_FLAG = SW'(2*NCH+1);

  logic [AW-1:0]  addr_q [NCH];
  cond_t          cond_q [NCH];
  logic [NCH-1:0] post_vec;
  logic [NCH-1:0] flag_vec;
  logic [NCH-1:0] armed_vec;
  logic [NCH-1:0] fetch_hit_vec;
  logic [NCH-1:0] hits_main;
  logic [NCH-1:0] hits_slot;
  logic [NCH-1:0] conf_hits;
  logic [NCH-1:0] pend_q;
  logic           exec;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    ifbrk_chan #(.AW(AW)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_addr   (cfg_we && (cfg_sel == SW'(2*c))),
      .wr_cond   (cfg_we && (cfg_sel == SW'(2*c+1))),
      .wr_post   (cfg_we && (cfg_sel == SEL_CTRL)),
      .post_wval (cfg_wdata[c]),
      .wdata     (cfg_wdata),
      .flag_we   (cfg_we && (cfg_sel == SEL_FLAG)),
      .flag_wval (cfg_wdata[c]),
      .flag_set  (conf_hits[c]),
      .fetch_addr(fetch_addr),
      .addr_q    (addr_q[c]),
      .cond_q    (cond_q[c]),
      .post_q    (post_vec[c]),
      .armed     (armed_vec[c]),
      .fetch_hit (fetch_hit_vec[c]),
      .flag_q    (flag_vec[c])
    );
  end

  ifbrk_tagtab #(.NCH(NCH), .TW(TW)) u_tab (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (fetch_valid),
    .wr_tag   (fetch_tag),
    .wr_hits  (fetch_hit_vec),
    .rd_tag_a (ret_tag),
    .rd_tag_b (ret_slot_tag),
    .rd_hits_a(hits_main),
    .rd_hits_b(hits_slot)
  );

  ifbrk_seq #(.NCH(NCH), .TW(TW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .ret_valid(ret_valid),
    .ret_cancel(ret_cancel),
    .ret_pair (ret_pair),
    .ret_tag  (ret_tag),
    .hits_main(hits_main),
    .hits_slot(hits_slot),
    .post_sel (post_vec),
    .blk      (cpu_block),
    .exec     (exec),
    .conf_hits(conf_hits),
    .pend_q   (pend_q),
    .brk_req  (brk_req),
    .brk_cause(brk_cause),
    .brk_tag  (brk_tag)
  );

  always_comb begin
    cfg_rdata = '0;
    for (int i = 0; i < NCH; i++) begin
      if (cfg_sel == SW'(2*i))   cfg_rdata = addr_q[i];
      if (cfg_sel == SW'(2*i+1)) cfg_rdata = AW'(cond_q[i]);
    end
    if (cfg_sel == SEL_CTRL) cfg_rdata = AW'(post_vec);
    if (cfg_sel == SEL_FLAG) cfg_rdata = AW'(flag_vec);
  end
endmodule

// File: rtl/ifbrk_checker.sv
`timescale 1ns/1ps
module ifbrk_checker #(
  parameter int NCH = 2,
  parameter int SW  = 3,
  parameter logic [SW-1:0] FLAG_SEL = '1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ret_valid,
  input logic             ret_cancel,
  input logic             cpu_block,
  input logic             cfg_we,
  input logic [SW-1:0]    cfg_sel,
  input logic [NCH-1:0]   wr_bits,
  input logic [NCH-1:0]   flag_vec,
  input logic             brk_req,
  input logic [2*NCH-1:0] brk_cause
);
  // R5: a request only follows an executed retire
  p_req_after_exec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> $past(ret_valid && !ret_cancel));

  // R7: a discarded instruction is followed by no request
  p_cancel_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && ret_cancel) |=> !brk_req);

  // R11: block bit suppresses the request
  p_block_silent_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_block |=> !brk_req);

  // R13: a request always carries a cause, and a quiet cycle none
  p_cause_present_r13: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req == (brk_cause != '0));

  // R13: before-execution cause bits have their flags set
  p_pre_flag_r13: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> ((brk_cause[NCH-1:0] & ~flag_vec) == '0));

  for (genvar c = 0; c < NCH; c++) begin : g_flag
    // R12: a flag falls only after a write of 0 to its bit
    p_flag_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_vec[c]) |-> $past(cfg_we && (cfg_sel == FLAG_SEL) && !wr_bits[c]));
  end
endmodule

bind ifbrk_unit ifbrk_checker #(.NCH(NCH), .SW(SW), .FLAG_SEL(SEL_FLAG)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ret_valid (ret_valid),
  .ret_cancel(ret_cancel),
  .cpu_block (cpu_block),
  .cfg_we    (cfg_we),
  .cfg_sel   (cfg_sel),
  .wr_bits   (cfg_wdata[NCH-1:0]),
  .flag_vec  (flag_vec),
  .brk_req   (brk_req),
  .brk_cause (brk_cause)
);

// File: tb/ifbrk_unit_test.sv
`timescale 1ns/1ps
module ifbrk_unit_test;
  localparam int NCH = 2;
  localparam int AW  = 16;
  localparam int TW  = 3;
  localparam int SW  = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [SW-1:0] cfg_sel = 3'd5;
  logic [AW-1:0] cfg_wdata = '0;
  logic [AW-1:0] cfg_rdata;
  logic          fetch_valid = 1'b0;
  logic [AW-1:0] fetch_addr = '0;
  logic [TW-1:0] fetch_tag = '0;
  logic          ret_valid = 1'b0;
  logic [TW-1:0] ret_tag = '0;
  logic          ret_cancel = 1'b0;
  logic          ret_pair = 1'b0;
  logic [TW-1:0] ret_slot_tag = '0;
  logic          cpu_block = 1'b0;
  logic          brk_req;
  logic [3:0]    brk_cause;
  logic [TW-1:0] brk_tag;

  ifbrk_unit #(.NCH(NCH), .AW(AW), .TW(TW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .fetch_valid(fetch_valid),
    .fetch_addr(fetch_addr), .fetch_tag(fetch_tag), .ret_valid(ret_valid),
    .ret_tag(ret_tag), .ret_cancel(ret_cancel), .ret_pair(ret_pair),
    .ret_slot_tag(ret_slot_tag), .cpu_block(cpu_block), .brk_req(brk_req),
    .brk_cause(brk_cause), .brk_tag(brk_tag)
  );

  always #10 clk = ~clk;

  int    n_checks = 0;
  int    n_fail = 0;
  string cur_req = "R1";
  int    pulses = 0;
  int    last_tag = -1;
  int    last_cause = 0;
  bit    done = 1'b0;

  // reference model state
  logic [AW-1:0] m_addr [2];
  logic [7:0]    m_cond [2];
  logic [1:0]    m_post, m_flag, m_pend;
  bit   [1:0]    m_tab [int];
  logic          e_req;
  logic [3:0]    e_cause;
  logic [TW-1:0] e_tag;

  function automatic bit m_armed(input int c);
    logic [7:0] w;
    w = m_cond[c];
    return w[1:0] == 2'd1 && w[3:2] == 2'd1 && w[5:4] == 2'd1 && w[7] == 1'b1
           && m_addr[c][0] == 1'b0;
  endfunction

  function automatic bit [1:0] m_look(input logic [TW-1:0] t);
    if (m_tab.exists(int'(t))) return m_tab[int'(t)];
    return 2'b00;
  endfunction

  always @(posedge clk) begin
    bit [1:0] conf, pre, fh;
    bit [3:0] fv;
    bit       ex;
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin m_addr[c] = '0; m_cond[c] = '0; end
      m_post = '0; m_flag = '0; m_pend = '0; m_tab.delete();
      e_req = 1'b0; e_cause = '0; e_tag = '0;
    end else begin
      ex = ret_valid && !ret_cancel;
      conf = 2'b00;
      if (ex) begin
        conf = m_look(ret_tag);
        if (ret_pair) conf = conf | m_look(ret_slot_tag);
      end
      pre = conf & ~m_post;
      fv  = {(ex ? m_pend : 2'b00), pre};
      e_req   = (fv != 0) && !cpu_block;
      e_cause = e_req ? fv : 4'd0;
      e_tag   = e_req ? ret_tag : '0;
      if (ex) m_pend = conf & m_post;
      for (int c = 0; c < 2; c++) fh[c] = m_armed(c) && (fetch_addr == m_addr[c]);
      if (fetch_valid) m_tab[int'(fetch_tag)] = fh;
      if (cfg_we && cfg_sel == 3'd5) m_flag = m_flag & cfg_wdata[1:0];
      m_flag = m_flag | conf;
      if (cfg_we) begin
        case (cfg_sel)
          3'd0: m_addr[0] = cfg_wdata;
          3'd1: m_cond[0] = cfg_wdata[7:0];
          3'd2: m_addr[1] = cfg_wdata;
          3'd3: m_cond[1] = cfg_wdata[7:0];
          3'd4: m_post = cfg_wdata[1:0];
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_checks++;
      if (brk_req !== e_req || brk_cause !== e_cause || brk_tag !== e_tag ||
          (cfg_sel == 3'd5 && cfg_rdata[1:0] !== m_flag)) begin
        n_fail++;
        $display("FAIL %s: req/cause/tag/flags = %b/%b/%0d/%b expected %b/%b/%0d/%b",
                 cur_req, brk_req, brk_cause, brk_tag, cfg_rdata[1:0],
                 e_req, e_cause, e_tag, m_flag);
      end
      if (brk_req) begin
        pulses++;
        last_tag = int'(brk_tag);
        last_cause = int'(brk_cause);
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
    fetch_valid = 1'b0; ret_valid = 1'b0; ret_cancel = 1'b0; ret_pair = 1'b0;
    cfg_we = 1'b0; cfg_sel = 3'd5;
  endtask

  task automatic wr(input int sel, input int data);
    cfg_we = 1'b1; cfg_sel = 3'(sel); cfg_wdata = AW'(data);
    tick();
  endtask

  task automatic rd_chk(input int sel, input int exp, input string req);
    cfg_sel = 3'(sel);
    #1;
    check(int'(cfg_rdata) == exp, req, int'(cfg_rdata), exp);
    cfg_sel = 3'd5;
  endtask

  task automatic fetch(input int a, input int t);
    fetch_valid = 1'b1; fetch_addr = AW'(a); fetch_tag = TW'(t);
    tick();
  endtask

  task automatic retire(input int t, input bit cancel);
    ret_valid = 1'b1; ret_tag = TW'(t); ret_cancel = cancel;
    tick();
  endtask

  task automatic retire_pair(input int t, input int s);
    ret_valid = 1'b1; ret_tag = TW'(t); ret_pair = 1'b1; ret_slot_tag = TW'(s);
    tick();
  endtask

  task automatic line(input int a0, input int n, input int t0);
    for (int i = 0; i < n; i++) begin
      fetch(a0 + 2*i, t0 + i);
      retire(t0 + i, 1'b0);
    end
  endtask

  task automatic phase(input string req);
    tick(); tick();
    cur_req = req;
    pulses = 0; last_tag = -1; last_cause = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R1: reset state
    check(brk_req == 1'b0 && brk_cause == 4'd0 && brk_tag == '0, "R1", int'(brk_cause), 0);
    for (int s = 0; s < 6; s++) rd_chk(s, 0, "R1");
    tick();

    phase("R14");
    wr(0, 'h0120); wr(1, 'h95); wr(2, 'h0140); wr(3, 'hD5); wr(4, 0);
    rd_chk(0, 'h0120, "R14"); rd_chk(1, 'h95, "R14");
    rd_chk(2, 'h0140, "R14"); rd_chk(3, 'hD5, "R14");
    wr(4, 2); rd_chk(4, 2, "R14"); wr(4, 0);

    phase("R4");  // R5 straight line, tags wrap through the table
    line('h0100, 40, 0);
    phase("R5");
    check(1, "R5", 0, 0);
    line('h0100, 40, 0);
    tick(); tick();
    check(pulses == 2, "R5", pulses, 2);
    rd_chk(5, 3, "R4");

    phase("R12");
    wr(5, 2); rd_chk(5, 2, "R12");
    wr(5, 0); rd_chk(5, 0, "R12");

    phase("R6");
    wr(4, 1);
    line('h011C, 4, 0);
    tick(); tick();
    check(pulses == 1 && last_tag == 3, "R6", last_tag, 3);
    check(last_cause == 4, "R6", last_cause, 4);

    phase("R7");
    fetch('h0140, 4); retire(4, 1'b1);
    tick();
    check(pulses == 0, "R7", pulses, 0);
    rd_chk(5, 1, "R7");
    fetch('h0120, 5); retire(5, 1'b0);
    fetch('h0122, 6); retire(6, 1'b1);
    fetch('h0130, 7); retire(7, 1'b0);
    tick(); tick();
    check(pulses == 1 && last_tag == 7, "R7", last_tag, 7);

    phase("R8");
    wr(4, 0); wr(0, 'h0202);
    fetch('h0200, 0); fetch('h0202, 1); retire_pair(0, 1);
    line('h0300, 2, 2);
    tick(); tick();
    check(pulses == 1 && last_tag == 0 && last_cause == 1, "R8", last_tag, 0);

    phase("R9");
    wr(4, 1);
    fetch('h0200, 3); fetch('h0202, 4); retire_pair(3, 4);
    tick();
    check(pulses == 0, "R9", pulses, 0);
    fetch('h0300, 5); retire(5, 1'b0);
    tick(); tick();
    check(pulses == 1 && last_tag == 5, "R9", last_tag, 5);
    wr(0, 'h0200);
    fetch('h0200, 6); fetch('h0202, 7); retire_pair(6, 7);
    fetch('h0300, 0); retire(0, 1'b0);
    tick(); tick();
    check(pulses == 2 && last_tag == 0 && last_cause == 4, "R9", last_tag, 0);

    phase("R10");
    fetch('h0200, 1); retire(1, 1'b0);
    fetch('h0202, 2); retire(2, 1'b0);
    tick(); tick();
    check(pulses == 1 && last_tag == 2, "R10", last_tag, 2);

    phase("R11");
    wr(4, 0); wr(5, 0);
    cpu_block = 1'b1;
    fetch('h0200, 3); retire(3, 1'b0);
    tick();
    rd_chk(5, 1, "R11");
    wr(4, 1);
    cpu_block = 1'b0;
    fetch('h0200, 4); retire(4, 1'b0);
    cpu_block = 1'b1;
    fetch('h0202, 5); retire(5, 1'b0);
    cpu_block = 1'b0;
    fetch('h0204, 6); retire(6, 1'b0);
    tick(); tick();
    check(pulses == 0, "R11", pulses, 0);

    phase("R13");
    wr(4, 0); wr(5, 0); wr(0, 'h0180); wr(2, 'h0180);
    fetch('h0180, 7); retire(7, 1'b0);
    tick(); tick();
    check(pulses == 1 && last_cause == 3 && last_tag == 7, "R13", last_cause, 3);
    rd_chk(5, 3, "R13");

    phase("R2");
    wr(1, 'h55); wr(3, 'hA5);
    line('h0180, 1, 0);
    wr(1, 'h99); wr(3, 'h96);
    line('h0180, 1, 1);
    tick(); tick();
    check(pulses == 0, "R2", pulses, 0);

    phase("R3");
    wr(1, 'h95); wr(3, 'hD5); wr(0, 'h0181); wr(2, 'h0181);
    line('h0180, 1, 2);
    fetch('h0181, 3); retire(3, 1'b0);
    tick(); tick();
    check(pulses == 0, "R3", pulses, 0);
    wr(0, 'h0180);
    line('h0180, 1, 4);
    tick(); tick();
    check(pulses == 1 && last_cause == 1, "R3", pulses, 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule